// File: doc/BRIEF.md
# Ageing Vector Address Generator

This block produces single-port RAM addresses for a sliding window of samples, of the kind a convolution or FIR filter reads. The samples never move inside the RAM. Each new sample lands in a free slot, or in the slot of the sample that is about to leave the window. A base pointer then rotates, so that logical index 0 always names the oldest sample and index `WIN_LEN-1` names the newest. One iteration of the filter therefore costs one RAM write per new sample. A shift would cost a read and a write for every element of the window.

The ageing step `AGE_STEP` is the largest number of new samples that one iteration can take, for example one per pipeline slice. The buffer holds `BUF = WIN_LEN + AGE_STEP - 1` slots, so the extra samples of a pipelined iteration go to spare slots. Only the last of them overwrites the oldest sample.

All modulo arithmetic uses compare-and-subtract, so neither `WIN_LEN` nor `BUF` has to be a power of two. A small state machine follows the warm-up:
- **FILL** is the state after reset. Reads of slots that do not yet hold a committed sample are flagged as misses.
- **FILL -> STEADY** is taken on the iteration strobe at which the committed sample count reaches `WIN_LEN`.
- **STEADY** is held from then on, and every in-range read is a hit.

Top module: `agevec_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the block drives `ram_we`, `ram_re` and `rd_hit` low. Reset puts the base pointer at slot 0, the committed count at zero and the state in FILL.
- R2: Within one iteration, the w-th accepted write (w counted from 0) addresses slot `(base + WIN_LEN + w) mod BUF`, where `BUF = WIN_LEN + AGE_STEP - 1`. Successive accepted writes therefore always address consecutive slots modulo `BUF`, and the `AGE_STEP`-th write of an iteration lands on the oldest sample's slot.
- R3: A write request beyond the `AGE_STEP`-th in one iteration is ignored: `ram_we` stays low and the window contents are unchanged.
- R4: On `iter_stb`, the base pointer advances modulo `BUF` by the number of writes accepted in that iteration, counting a write accepted in the same cycle. A write in the strobe cycle uses the base pointer from before the advance.
- R5: A read of logical index j (0 = oldest, `WIN_LEN-1` = newest) addresses slot `(base + j) mod BUF`. The RAM word found there equals element j of a shift-register window that holds the last `WIN_LEN` committed samples.
- R6: While fewer than `WIN_LEN` samples are committed (state FILL), `rd_hit` is high only for `j >= WIN_LEN - committed`. Once `WIN_LEN` samples are committed (state STEADY), every in-range read has `rd_hit` high.
- R7: A read request with `rd_idx >= WIN_LEN` is not performed: `ram_re` and `rd_hit` stay low.
- R8: When `wr_req` and `rd_req` are both high in one cycle, the write takes the single RAM port and the read is dropped (`ram_re` low).
- R9: `ram_addr`, `ram_we`, `ram_re` and `rd_hit` are registered. They reflect the request sampled at the previous rising clock edge.
- R10: An `iter_stb` with no accepted write in its iteration leaves the base pointer and the window unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iter_stb | input | 1 | End of filter iteration; commits this iteration's new samples |
| wr_req | input | 1 | Request to write one new sample |
| rd_req | input | 1 | Request to read one window element |
| rd_idx | input | $clog2(WIN_LEN) | Logical index of the element to read (0 = oldest) |
| ram_addr | output | $clog2(BUF) | Physical RAM address for the current access |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| rd_hit | output | 1 | The read slot holds a committed sample |

## Verification
The bound checker checks properties of the RAM port on every cycle:
- A write and a read never happen in the same cycle.
- Every access stays below `BUF`.
- Successive writes step by exactly one slot modulo `BUF`.
- A hit never comes without a read, and never before the first write.
- Each enable traces back to a request one cycle earlier.

Whether the data read back is the right sample needs the bench's scenarios. The bench keeps a RAM model and a shift-register window model, and compares every read across:
- warm-up;
- single-write and double-write iterations;
- ignored surplus writes;
- strobes with no new sample;
- out-of-range indices;
- write/read collisions.

// File: rtl/avg_pkg.sv
package avg_pkg;
    typedef enum logic [0:0] {
        AVG_FILL   = 1'b0,
        AVG_STEADY = 1'b1
    } avg_state_e;
endpackage

// File: rtl/avg_modadd.sv
// (a + b) mod MOD by one compare-and-subtract; valid for a < MOD, b <= MOD.
module avg_modadd #(
    parameter int W   = 4,
    parameter int MOD = 6
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    localparam logic [W:0] M_W = (W+1)'(MOD);

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        if (sum >= M_W) begin
            y = W'(sum - M_W);
        end else begin
            y = sum[W-1:0];
        end
    end
endmodule

// File: rtl/avg_base_ptr.sv
// Base pointer, per-iteration write counter and the two address adders.
module avg_base_ptr #(
    parameter int WIN_LEN  = 5,
    parameter int AGE_STEP = 2,
    parameter int BUF      = 6,
    parameter int AW       = 3,
    parameter int OW       = 4,
    parameter int CW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iter_stb,
    input  logic          wr_req,
    input  logic [OW-1:0] rd_idx_x,
    output logic          wr_ok,
    output logic [OW-1:0] adv_n,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);
    localparam logic [CW-1:0] STEP_C = CW'(AGE_STEP);
    localparam logic [OW-1:0] LEN_W  = OW'(WIN_LEN);

    logic [AW-1:0] base_q;
    logic [CW-1:0] wcnt_q;
    logic [OW-1:0] base_x;
    logic [OW-1:0] wr_off;
    logic [OW-1:0] adv_sum;
    logic [OW-1:0] wr_sum;
    logic [OW-1:0] rd_sum;

    assign base_x = {1'b0, base_q};
    assign wr_ok  = wr_req && (wcnt_q < STEP_C);
    assign adv_n  = OW'(wcnt_q) + OW'(wr_ok);
    assign wr_off = LEN_W + OW'(wcnt_q);

    avg_modadd #(.W(OW), .MOD(BUF)) u_adv (.a(base_x), .b(adv_n),    .y(adv_sum));
    avg_modadd #(.W(OW), .MOD(BUF)) u_wra (.a(base_x), .b(wr_off),   .y(wr_sum));
    avg_modadd #(.W(OW), .MOD(BUF)) u_rda (.a(base_x), .b(rd_idx_x), .y(rd_sum));

    assign wr_addr = wr_sum[AW-1:0];
    assign rd_addr = rd_sum[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            wcnt_q <= '0;
        end else if (iter_stb) begin
            base_q <= adv_sum[AW-1:0];
            wcnt_q <= '0;
        end else if (wr_ok) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/avg_window_fsm.sv
// Warm-up tracking: FILL until WIN_LEN samples are committed, then STEADY.
module avg_window_fsm
    import avg_pkg::*;
#(
    parameter int WIN_LEN = 5,
    parameter int OW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iter_stb,
    input  logic [OW-1:0] adv_n,
    input  logic [OW-1:0] rd_idx_x,
    output logic          slot_hit,
    output avg_state_e    state
);
    localparam logic [OW-1:0] LEN_W = OW'(WIN_LEN);

    avg_state_e    state_q;
    avg_state_e    state_d;
    logic [OW-1:0] fill_q;
    logic [OW-1:0] fill_sum;
    logic [OW-1:0] fill_sat;

    assign fill_sum = fill_q + adv_n;
    assign fill_sat = (fill_sum >= LEN_W) ? LEN_W : fill_sum;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AVG_FILL:   if (iter_stb && (fill_sum >= LEN_W)) state_d = AVG_STEADY;
            AVG_STEADY: state_d = AVG_STEADY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AVG_FILL;
            fill_q  <= '0;
        end else begin
            state_q <= state_d;
            if (iter_stb && (state_q == AVG_FILL)) begin
                fill_q <= fill_sat;
            end
        end
    end

    always_comb begin
        slot_hit = 1'b0;
        unique case (state_q)
            AVG_FILL:   slot_hit = (rd_idx_x >= (LEN_W - fill_q));
            AVG_STEADY: slot_hit = 1'b1;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/agevec_addr_gen.sv
module agevec_addr_gen #(
    parameter int WIN_LEN  = 5,
    parameter int AGE_STEP = 2,
    localparam int BUF     = WIN_LEN + AGE_STEP - 1,
    localparam int IW      = $clog2(WIN_LEN),
    localparam int AW      = $clog2(BUF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iter_stb,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          ram_re,
    output logic          rd_hit
);
    import avg_pkg::*;

    localparam int OW = AW + 1;
    localparam int CW = $clog2(AGE_STEP + 1);
    localparam logic [OW-1:0] LEN_W = OW'(WIN_LEN);

    logic [OW-1:0] rd_idx_x;
    logic          wr_ok;
    logic [OW-1:0] adv_n;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          slot_hit;
    avg_state_e    win_state;
    logic          rd_go;

    assign rd_idx_x = OW'(rd_idx);
    assign rd_go    = rd_req && !wr_req && (rd_idx_x < LEN_W);

    avg_base_ptr #(
        .WIN_LEN(WIN_LEN), .AGE_STEP(AGE_STEP), .BUF(BUF),
        .AW(AW), .OW(OW), .CW(CW)
    ) u_base (
        .clk(clk), .rst_n(rst_n), .iter_stb(iter_stb), .wr_req(wr_req),
        .rd_idx_x(rd_idx_x), .wr_ok(wr_ok), .adv_n(adv_n),
        .wr_addr(wr_addr), .rd_addr(rd_addr)
    );

    avg_window_fsm #(.WIN_LEN(WIN_LEN), .OW(OW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .iter_stb(iter_stb), .adv_n(adv_n),
        .rd_idx_x(rd_idx_x), .slot_hit(slot_hit), .state(win_state)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_addr <= '0;
            ram_we   <= 1'b0;
            ram_re   <= 1'b0;
            rd_hit   <= 1'b0;
        end else begin
            ram_we <= wr_ok;
            ram_re <= rd_go;
            rd_hit <= rd_go && slot_hit && (win_state inside {AVG_FILL, AVG_STEADY});
            if (wr_ok) begin
                ram_addr <= wr_addr;
            end else if (rd_go) begin
                ram_addr <= rd_addr;
            end
        end
    end
endmodule

// File: rtl/avg_chk.sv
module avg_chk #(
    parameter int BUF = 6,
    parameter int AW  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_req,
    input logic          rd_req,
    input logic [AW-1:0] ram_addr,
    input logic          ram_we,
    input logic          ram_re,
    input logic          rd_hit
);
    localparam logic [AW-1:0] TOP_A = AW'(BUF - 1);

    logic [AW-1:0] last_wa;
    logic          have_wa;
    logic [AW-1:0] next_wa;

    assign next_wa = (last_wa == TOP_A) ? '0 : last_wa + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_wa <= '0;
            have_wa <= 1'b0;
        end else if (ram_we) begin
            last_wa <= ram_addr;
            have_wa <= 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ram_we && !ram_re && !rd_hit));

    p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && have_wa) |-> (ram_addr == next_wa));

    p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_addr <= TOP_A));

    p_hit_needs_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> ram_re);

    p_hit_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> have_wa);

    p_port_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    p_we_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(wr_req));

    p_re_from_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> $past(rd_req && !wr_req));
endmodule

bind agevec_addr_gen avg_chk #(.BUF(BUF), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re), .rd_hit(rd_hit)
);

// File: tb/agevec_addr_gen_bench.sv
module agevec_addr_gen_bench;
    localparam int L   = 5;
    localparam int K   = 2;
    localparam int BUF = L + K - 1;
    localparam int IW  = $clog2(L);
    localparam int AW  = $clog2(BUF);

    localparam int K_IDLE   = 0;
    localparam int K_WR     = 1;
    localparam int K_WR_IGN = 2;
    localparam int K_RD     = 3;
    localparam int K_RD_DRP = 4;

    typedef struct {
        int kind;
        int tag;
        int valid;
        int data;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iter_stb = 1'b0;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic          ram_re;
    logic          rd_hit;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    int    next_data = 100;
    int    bench_mem [BUF];
    int    win [$];
    int    pend [$];
    item_t scb [$];

    always #5 clk = ~clk;

    agevec_addr_gen #(.WIN_LEN(L), .AGE_STEP(K)) u_agevec_addr_gen (
        .clk(clk), .rst_n(rst_n), .iter_stb(iter_stb), .wr_req(wr_req),
        .rd_req(rd_req), .rd_idx(rd_idx), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_re(ram_re), .rd_hit(rd_hit)
    );

    task automatic chk(input bit ok, input int tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: outputs registered at a rising edge are compared 2 ns later.
    always begin
        item_t it;
        @(posedge clk);
        #2;
        if (rst_n && scb.size() > 0) begin
            it = scb.pop_front();
            case (it.kind)
                K_IDLE: chk(!ram_we && !ram_re && !rd_hit, it.tag,
                            {ram_we, ram_re, rd_hit}, 0);
                K_WR: begin
                    chk(ram_we && !ram_re, it.tag, {ram_we, ram_re}, 2);
                    if (ram_we && int'(ram_addr) < BUF) bench_mem[ram_addr] = it.data;
                end
                K_WR_IGN: chk(!ram_we && !ram_re, it.tag, {ram_we, ram_re}, 0);
                K_RD: begin
                    chk(ram_re, it.tag, ram_re, 1);
                    chk(int'(rd_hit) == it.valid, it.tag, rd_hit, it.valid);
                    if (it.valid != 0 && ram_re)
                        chk(bench_mem[ram_addr] == it.data, it.tag,
                            bench_mem[ram_addr], it.data);
                end
                default: chk(!ram_re && !rd_hit, it.tag, {ram_re, rd_hit}, 0);
            endcase
        end
    end

    // Driver: applies one cycle of requests and pushes the expected result.
    task automatic step(input bit wr, input bit stb, input bit rd, input int idx,
                        input int tag);
        item_t it;
        int    first;
        @(negedge clk);
        wr_req   = wr;
        iter_stb = stb;
        rd_req   = rd;
        rd_idx   = IW'(idx);
        it.tag   = tag;
        it.valid = 0;
        it.data  = 0;
        if (wr) begin
            if (pend.size() < K) begin
                it.kind = K_WR;
                it.data = next_data;
                pend.push_back(next_data);
            end else begin
                it.kind = K_WR_IGN;
            end
            next_data++;
        end else if (rd) begin
            if (idx >= L) begin
                it.kind = K_RD_DRP;
            end else begin
                it.kind = K_RD;
                first = L - win.size();
                if (idx >= first) begin
                    it.valid = 1;
                    it.data  = win[idx - first];
                end
            end
        end else begin
            it.kind = K_IDLE;
        end
        if (stb) begin
            foreach (pend[i]) win.push_back(pend[i]);
            while (win.size() > L) void'(win.pop_front());
            pend.delete();
        end
        scb.push_back(it);
    endtask

    task automatic read_all(input int tag);
        for (int j = 0; j < L; j++) step(1'b0, 1'b0, 1'b1, j, tag);
    endtask

    initial begin
        for (int i = 0; i < BUF; i++) bench_mem[i] = -1;
        repeat (3) @(posedge clk);
        #2;
        chk(!ram_we && !ram_re && !rd_hit, 1, {ram_we, ram_re, rd_hit}, 0); // R1
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 0, 1);                // R1 quiet after release
        step(1'b0, 1'b0, 1'b1, 4, 6);                // R6 empty window miss

        // Warm-up with two samples per iteration: R2, R4, R6 then R5
        for (int it = 0; it < 4; it++) begin
            step(1'b1, 1'b0, 1'b0, 0, 2);
            step(1'b1, 1'b1, 1'b0, 0, 4);
            read_all(it < 2 ? 6 : 5);
        end

        // R2 free slot: read mid-iteration after the first write
        step(1'b1, 1'b0, 1'b0, 0, 2);
        step(1'b0, 1'b0, 1'b1, 0, 2);
        step(1'b0, 1'b0, 1'b1, 4, 2);
        step(1'b1, 1'b1, 1'b0, 0, 2);
        read_all(5);

        // R3 surplus write ignored, strobe on its own
        step(1'b1, 1'b0, 1'b0, 0, 3);
        step(1'b1, 1'b0, 1'b0, 0, 3);
        step(1'b1, 1'b0, 1'b0, 0, 3);
        step(1'b0, 1'b1, 1'b0, 0, 4);
        read_all(3);

        // R10 strobe with no write leaves the window unchanged
        step(1'b0, 1'b1, 1'b0, 0, 10);
        read_all(10);

        // R4 one sample per iteration, odd base advance
        for (int it = 0; it < 3; it++) begin
            step(1'b1, 1'b1, 1'b0, 0, 4);
            read_all(4);
        end

        // R7 out-of-range indices
        for (int j = L; j < (1 << IW); j++) step(1'b0, 1'b0, 1'b1, j, 7);

        // R8 write and read together: write wins
        step(1'b1, 1'b0, 1'b1, 2, 8);
        step(1'b1, 1'b1, 1'b1, 0, 8);
        read_all(8);

        step(1'b0, 1'b0, 1'b0, 0, 9);                // R9 idle after traffic
        step(1'b0, 1'b0, 1'b0, 0, 9);
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R9: watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule